// File: doc/BRIEF.md
# Multi-Channel Scan Sampler with DMA Write Handshake

The block sequences conversions over a set of sampling channels and writes each result into memory through a simple write-request/acknowledge port. A pulse on the sample trigger walks once through every enabled channel, lowest index first. Each channel takes a fixed number of cycles to convert, and the result is presented on the memory port right away. A pulse on the start trigger copies a shadow pointer and word count into the active buffer registers. Software can therefore program the next buffer while the current one is filling. When the programmed count of words has been written, an end pulse is raised and the buffer disarms.

Results wait in one holding slot. The sequencer never waits for memory. If no buffer is armed while a scan runs, later conversions overwrite the slot. When start finally arrives, only the newest result is written. This rotates the channel order in memory, which is the behaviour the block deliberately keeps. An optional link mode re-arms the buffer in hardware on every end pulse, which prevents that loss.

Top module: `scan_sampler`

## Requirements
- R1: A scan converts only the channels whose bit in `chanEnable` is 1, in ascending index order, and writes one word per converted channel. With no channel enabled, the sample trigger does nothing.
- R2: A channel's result is captured `CONV_LAT` cycles after the channel is selected on `convChan`. `convData` is sampled in the last of those cycles. With an armed buffer, `dmaReq` rises in the cycle after the capture.
- R3: When a capture lands while the slot still holds an unwritten result that is not being written in that cycle, the old result is discarded and `overflowPulse` is high for one cycle.
- R4: `dmaReq` is high only while a buffer is armed and the slot holds a result. A write takes place in a cycle where `dmaReq` and `dmaAck` are both high. Word k of a buffer goes to address pointer+k, with the address counting in whole words.
- R5: After the last word of the programmed count is written, `endEvent` is high for exactly one cycle. No further request is raised until the buffer is re-armed.
- R6: If a scan runs while no buffer is armed, the next start causes only the most recently converted channel to be written. The earlier channels of that scan are lost, and the channel order in memory rotates.
- R7: When `linkMode` is 1, each end pulse re-arms the buffer from the shadow registers in the following cycle. Back-to-back scans then store channels in ascending order in every buffer.
- R8: A sample trigger that arrives while a scan is in progress is ignored. `trigIgnored` pulses for one cycle, and the running scan writes exactly one word per enabled channel.
- R9: A start trigger copies `shadowPtr` and `shadowLen` into the active registers. A length of zero leaves the buffer disarmed, so no request is raised.
- R10: After reset, no buffer is armed, `dmaAddr` is 0, `dmaReq`, `endEvent` and `scanBusy` are 0, and nothing is held in the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTask | input | 1 | Pulse that starts one scan |
| startTask | input | 1 | Pulse that arms a buffer from the shadow registers |
| linkMode | input | 1 | 1: re-arm automatically on every end pulse |
| chanEnable | input | NUM_CH | Per-channel enable |
| shadowPtr | input | ADDR_W | Next buffer word address |
| shadowLen | input | LEN_W | Next buffer length in words |
| convChan | output | CH_W | Channel currently being converted |
| convData | input | DATA_W | Conversion result for `convChan` |
| dmaReq | output | 1 | Memory write request |
| dmaAck | input | 1 | Memory write acknowledge |
| dmaAddr | output | ADDR_W | Write word address |
| dmaData | output | DATA_W | Write data |
| endEvent | output | 1 | One-cycle pulse when the buffer is full |
| overflowPulse | output | 1 | One-cycle pulse when a held result is overwritten |
| trigIgnored | output | 1 | One-cycle pulse when a sample trigger is dropped |
| scanBusy | output | 1 | A scan is in progress |

## Verification
On every cycle, the assertions check four things:
- the end pulse lasts one cycle, follows a write, and never coincides with a request;
- a waiting request keeps its address;
- overflow and ignored-trigger pulses only follow a busy scan;
- the selected channel is always enabled.

Only the directed scenarios can show the ordering effects: the rotated channel order after a late start, the in-order buffers in link mode, the skipping of disabled channels, and the capture latency. Those depend on sequences of triggers across whole buffers.

// File: rtl/sampler_pkg.sv
package sampler_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch convData into the holding slot
    logic arm;      // copy shadow pointer/length into the active buffer
  } ctrlStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import sampler_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CONV_LAT = 3,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LAT_W   = $clog2(CONV_LAT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTask,
  input  logic              startTask,
  input  logic              linkMode,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic              endEvent,
  output ctrlStrobe_t       strobe,
  output logic [CH_W-1:0]   convChan,
  output logic              busy,
  output logic              trigIgnored
);
  logic [LAT_W-1:0] latCnt;
  logic             firstFound, nextFound;
  logic [CH_W-1:0]  firstIdx, nextIdx;
  logic             lastCycle;

  // lowest enabled channel, and lowest enabled channel above the current one
  always_comb begin
    firstFound = 1'b0;
    firstIdx   = '0;
    nextFound  = 1'b0;
    nextIdx    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chanEnable[i]) begin
        firstFound = 1'b1;
        firstIdx   = CH_W'(i);
      end
      if (chanEnable[i] && (i > int'(convChan))) begin
        nextFound = 1'b1;
        nextIdx   = CH_W'(i);
      end
    end
  end

  assign lastCycle      = busy && (latCnt == LAT_W'(CONV_LAT - 1));
  assign strobe.capture = lastCycle;
  assign strobe.arm     = startTask || (linkMode && endEvent);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      convChan    <= '0;
      latCnt      <= '0;
      trigIgnored <= 1'b0;
    end else begin
      trigIgnored <= busy && sampleTask;
      if (!busy) begin
        if (sampleTask && firstFound) begin
          busy     <= 1'b1;
          convChan <= firstIdx;
          latCnt   <= '0;
        end
      end else if (lastCycle) begin
        latCnt <= '0;
        if (nextFound) convChan <= nextIdx;
        else           busy     <= 1'b0;
      end else begin
        latCnt <= latCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import sampler_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] convData,
  input  logic [ADDR_W-1:0] shadowPtr,
  input  logic [LEN_W-1:0]  shadowLen,
  input  logic              dmaAck,
  output logic              dmaReq,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [DATA_W-1:0] dmaData,
  output logic              endEvent,
  output logic              overflowPulse
);
  logic [DATA_W-1:0] slotData;
  logic              slotValid;
  logic              armed;
  logic [ADDR_W-1:0] wrAddr;
  logic [LEN_W-1:0]  remaining;
  logic              transfer;

  assign dmaReq   = slotValid && armed;
  assign transfer = dmaReq && dmaAck;
  assign dmaAddr  = wrAddr;
  assign dmaData  = slotData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotData      <= '0;
      slotValid     <= 1'b0;
      armed         <= 1'b0;
      wrAddr        <= '0;
      remaining     <= '0;
      endEvent      <= 1'b0;
      overflowPulse <= 1'b0;
    end else begin
      overflowPulse <= 1'b0;
      endEvent      <= transfer && (remaining == LEN_W'(1));

      // single holding slot: a new result always wins
      if (strobe.capture) begin
        slotData      <= convData;
        slotValid     <= 1'b1;
        overflowPulse <= slotValid && !transfer;
      end else if (transfer) begin
        slotValid <= 1'b0;
      end

      if (strobe.arm) begin
        wrAddr    <= shadowPtr;
        remaining <= shadowLen;
        armed     <= (shadowLen != '0);
      end else if (transfer) begin
        wrAddr    <= wrAddr + 1'b1;
        remaining <= remaining - 1'b1;
        if (remaining == LEN_W'(1)) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scan_sampler.sv
module scan_sampler
  import sampler_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CONV_LAT = 3,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 12,
  parameter int LEN_W    = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTask,
  input  logic              startTask,
  input  logic              linkMode,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic [ADDR_W-1:0] shadowPtr,
  input  logic [LEN_W-1:0]  shadowLen,
  output logic [CH_W-1:0]   convChan,
  input  logic [DATA_W-1:0] convData,
  output logic              dmaReq,
  input  logic              dmaAck,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [DATA_W-1:0] dmaData,
  output logic              endEvent,
  output logic              overflowPulse,
  output logic              trigIgnored,
  output logic              scanBusy
);
  ctrlStrobe_t strobe;

  scan_ctrl #(.NUM_CH(NUM_CH), .CONV_LAT(CONV_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTask(sampleTask), .startTask(startTask),
    .linkMode(linkMode), .chanEnable(chanEnable), .endEvent(endEvent),
    .strobe(strobe), .convChan(convChan), .busy(scanBusy), .trigIgnored(trigIgnored)
  );

  scan_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convData(convData),
    .shadowPtr(shadowPtr), .shadowLen(shadowLen), .dmaAck(dmaAck),
    .dmaReq(dmaReq), .dmaAddr(dmaAddr), .dmaData(dmaData),
    .endEvent(endEvent), .overflowPulse(overflowPulse)
  );
endmodule

// File: rtl/scan_sampler_checker.sv
module scan_sampler_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleTask,
  input logic              startTask,
  input logic [NUM_CH-1:0] chanEnable,
  input logic [CH_W-1:0]   convChan,
  input logic              dmaReq,
  input logic              dmaAck,
  input logic [ADDR_W-1:0] dmaAddr,
  input logic              endEvent,
  input logic              overflowPulse,
  input logic              trigIgnored,
  input logic              scanBusy
);
  p_end_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    endEvent |=> !endEvent);

  p_end_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    endEvent |-> $past(dmaReq && dmaAck));

  p_end_no_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    endEvent |-> !dmaReq);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck && !startTask) |=> (dmaReq && $stable(dmaAddr)));

  p_no_overflow_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> $past(scanBusy));

  p_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigIgnored |-> $past(scanBusy && sampleTask));

  p_chan_enabled_r1: assert property (@(posedge clk) disable iff (!rstN)
    scanBusy |-> chanEnable[convChan]);
endmodule

bind scan_sampler scan_sampler_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTask(sampleTask), .startTask(startTask),
  .chanEnable(chanEnable), .convChan(convChan), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .dmaAddr(dmaAddr), .endEvent(endEvent), .overflowPulse(overflowPulse),
  .trigIgnored(trigIgnored), .scanBusy(scanBusy)
);

// File: tb/sim_scan_sampler.sv
`timescale 1ns/1ps
module sim_scan_sampler;
  localparam int NUM_CH = 4, CONV_LAT = 3, ADDR_W = 16, DATA_W = 12, LEN_W = 8;
  localparam int CH_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic sampleTask = 0, startTask = 0, linkMode = 0, dmaAck = 1;
  logic [NUM_CH-1:0] chanEnable = '1;
  logic [ADDR_W-1:0] shadowPtr = '0;
  logic [LEN_W-1:0]  shadowLen = '0;
  logic [CH_W-1:0]   convChan;
  logic [DATA_W-1:0] convData, dmaData;
  logic [ADDR_W-1:0] dmaAddr;
  logic dmaReq, endEvent, overflowPulse, trigIgnored, scanBusy;

  int checks = 0, fails = 0;
  int writeCnt = 0, endCnt = 0, ovfCnt = 0, ignCnt = 0;
  logic [DATA_W-1:0] mem [0:255];
  bit done = 0;

  always #2.5 clk = ~clk;

  // conversion result identifies its channel
  assign convData = DATA_W'(12'hA00) + DATA_W'(convChan);

  scan_sampler #(.NUM_CH(NUM_CH), .CONV_LAT(CONV_LAT), .ADDR_W(ADDR_W),
                 .DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rstN(rstN), .sampleTask(sampleTask), .startTask(startTask),
    .linkMode(linkMode), .chanEnable(chanEnable), .shadowPtr(shadowPtr),
    .shadowLen(shadowLen), .convChan(convChan), .convData(convData),
    .dmaReq(dmaReq), .dmaAck(dmaAck), .dmaAddr(dmaAddr), .dmaData(dmaData),
    .endEvent(endEvent), .overflowPulse(overflowPulse),
    .trigIgnored(trigIgnored), .scanBusy(scanBusy)
  );

  // port monitor: a write happens at the posedge after a negedge with req&ack
  always @(negedge clk) if (rstN) begin
    if (dmaReq && dmaAck) begin
      mem[dmaAddr[7:0]] = dmaData;
      writeCnt++;
    end
    if (endEvent) endCnt++;
    if (overflowPulse) ovfCnt++;
    if (trigIgnored) ignCnt++;
  end

  function automatic logic [DATA_W-1:0] dv(input int ch);
    return DATA_W'(12'hA00 + ch);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; sampleTask = 0; startTask = 0; linkMode = 0; chanEnable = '1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
    rstN = 1;
    writeCnt = 0; endCnt = 0; ovfCnt = 0; ignCnt = 0;
  endtask

  task automatic pulseStart(input int ptr, input int len);
    @(negedge clk);
    shadowPtr = ADDR_W'(ptr); shadowLen = LEN_W'(len); startTask = 1;
    @(negedge clk);
    startTask = 0;
  endtask

  task automatic pulseSample();
    @(negedge clk); sampleTask = 1;
    @(negedge clk); sampleTask = 0;
  endtask

  task automatic waitScan();
    repeat (NUM_CH * CONV_LAT + 6) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check(dmaReq == 0, "R10 req", dmaReq, 0);
    check(dmaAddr == 0, "R10 addr", dmaAddr, 0);
    check(endEvent == 0 && scanBusy == 0, "R10 end/busy", {endEvent, scanBusy}, 0);
    pulseStart(8, 1);
    repeat (2) @(negedge clk);
    check(writeCnt == 0, "R10 empty slot", writeCnt, 0);
  endtask

  task automatic testInOrderAndLatency();
    doReset();
    pulseStart(8'h10, 4);
    @(negedge clk); sampleTask = 1;
    @(negedge clk); sampleTask = 0;
    check(scanBusy == 1 && convChan == 0, "R2 select ch0", convChan, 0);
    repeat (CONV_LAT - 1) @(negedge clk);
    check(dmaReq == 0, "R2 not early", dmaReq, 0);
    @(negedge clk);
    check(dmaReq == 1 && dmaAddr == 16'h10, "R2 req after latency", dmaAddr, 16'h10);
    waitScan();
    for (int k = 0; k < 4; k++)
      check(mem[8'h10 + k] == dv(k), "R1 R4 order", mem[8'h10 + k], dv(k));
    check(endCnt == 1, "R5 end once", endCnt, 1);
    check(ovfCnt == 0, "R3 no overflow", ovfCnt, 0);
    pulseSample();
    waitScan();
    check(writeCnt == 4, "R5 no write after end", writeCnt, 4);
  endtask

  task automatic testLateStart();
    doReset();
    pulseStart(8'h10, 4);
    pulseSample(); waitScan();
    pulseSample(); waitScan();
    check(dmaReq == 0, "R5 pending held", dmaReq, 0);
    check(ovfCnt == 3, "R3 overflow count", ovfCnt, 3);
    pulseStart(8'h20, 4);
    @(negedge clk);
    pulseSample(); waitScan();
    check(mem[8'h20] == dv(3), "R6 newest first", mem[8'h20], dv(3));
    for (int k = 1; k < 4; k++)
      check(mem[8'h20 + k] == dv(k - 1), "R6 rotated", mem[8'h20 + k], dv(k - 1));
    check(endCnt == 2, "R6 end count", endCnt, 2);
  endtask

  task automatic testLink();
    doReset();
    linkMode = 1;
    pulseStart(8'h40, 4);
    shadowPtr = 16'h50;
    pulseSample(); waitScan();
    pulseSample(); waitScan();
    for (int k = 0; k < 4; k++) begin
      check(mem[8'h40 + k] == dv(k), "R7 first buffer", mem[8'h40 + k], dv(k));
      check(mem[8'h50 + k] == dv(k), "R7 second buffer", mem[8'h50 + k], dv(k));
    end
    check(ovfCnt == 0, "R7 no loss", ovfCnt, 0);
  endtask

  task automatic testIgnored();
    doReset();
    pulseStart(8'h60, 8);
    pulseSample();
    @(negedge clk); sampleTask = 1;
    @(negedge clk); sampleTask = 0;
    waitScan();
    check(ignCnt == 1, "R8 ignored pulse", ignCnt, 1);
    check(writeCnt == 4, "R8 one scan only", writeCnt, 4);
  endtask

  task automatic testDisabledAndZeroLen();
    doReset();
    chanEnable = 4'b1010;
    pulseStart(8'h70, 2);
    pulseSample(); waitScan();
    check(mem[8'h70] == dv(1) && mem[8'h71] == dv(3), "R1 skip disabled",
          mem[8'h70], dv(1));
    check(endCnt == 1 && writeCnt == 2, "R1 two words", writeCnt, 2);
    chanEnable = '0;
    pulseStart(8'h78, 2);
    pulseSample();
    @(negedge clk);
    check(scanBusy == 0, "R1 nothing enabled", scanBusy, 0);
    doReset();
    pulseStart(8'h80, 0);
    pulseSample(); waitScan();
    check(writeCnt == 0 && dmaReq == 0, "R9 zero length", writeCnt, 0);
  endtask

  initial begin
    testReset();
    testInOrderAndLatency();
    testLateStart();
    testLink();
    testIgnored();
    testDisabledAndZeroLen();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule